// File: doc/BRIEF.md
# Trap entry sequencer

This block computes the architectural side effects of entering a trap on a small 32-bit soft processor. Each cycle it may receive one or more trap requests: an MMU fault, a hardware exception, a hardware break, a software break or an external interrupt. It picks one by fixed priority and works out the new program counter, the link register write, the next machine status word, the exception status and fault address words, and the saved branch target. Alongside the request it takes the current PC, the delay-slot and immediate-prefix pipeline flags, the pending branch target, the faulting address and its access kind, and the current status words.

All results are registered on the clock edge that samples the request. They show up one cycle later as a `done` pulse, with one write-enable pulse for each destination. Each data output holds its last written value until a later trap writes it again, so the surrounding core can commit any field whose enable is high. The core resolves the delay-slot and prefix flags before it raises a request. This block adjusts the return address to match and tells the core when to clear those flags.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, every write enable, `clr_flags`, `recur_err` and every data output are zero.
- R2: A cycle with no request taken raises no `done` or write enable in the next cycle, and every data output keeps its value.
- R3: Priority from highest is MMU fault, hardware exception, hardware break, software break, interrupt. A hardware exception request with `exc_en` low is dropped: it changes nothing, and a lower request that is present is taken instead.
- R4: A hardware exception writes PC+4 to link register 17 and jumps to 0x20. ESR is `esr_in` with bit 12 cleared. If `in_dslot` is set, bit 12 is set instead and BTR is written with `br_target`.
- R5: An MMU fault writes a return address to link register 17 and jumps to 0x20. The return address is PC-8 when both `in_dslot` and `br_imm` are set, PC-4 when only `in_dslot` is set, PC-4 when only `in_imm` is set, and PC otherwise. In a delay slot, ESR bit 12 is set and BTR is written with `br_target`.
- R6: An MMU fault writes EAR with `flt_addr`. It writes ESR low bits 16 (protection fault, data access), 17 (protection fault, fetch), 18 (TLB miss, data) or 19 (TLB miss, fetch), where `flt_miss`=1 means a miss. Bit 10 is set when `acc_kind`=01 (store). `acc_kind`=10 is a fetch, and 00 and 11 are loads.
- R7: Every taken trap writes MSR with bit 14 set to the old bit 13 and bit 12 set to the old bit 11, then clears bits 13 and 11. MMU faults and hardware exceptions also set bit 9. Other MSR bits pass through unchanged unless another requirement names them.
- R8: An interrupt writes PC to link register 14, clears MSR bit 1 and jumps to 0x10.
- R9: A hardware break writes PC to link register 16, sets MSR bit 3 and jumps to 0x18.
- R10: A software break sets MSR bit 3, jumps to `br_target` and writes no link register.
- R11: `clr_flags` pulses with `done` on hardware exception and MMU fault entries only.
- R12: `recur_err` pulses with `done` when an MMU fault is taken and the previously taken trap was also an MMU fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_en | input | 1 | Hardware exception support enabled |
| req_mmu | input | 1 | MMU fault request |
| req_hwexc | input | 1 | Hardware exception request |
| req_hwbrk | input | 1 | Hardware break request |
| req_swbrk | input | 1 | Software break request |
| req_irq | input | 1 | External interrupt request |
| pc | input | 32 | PC of the trapping instruction |
| in_dslot | input | 1 | Instruction sits in a branch delay slot |
| in_imm | input | 1 | Instruction follows an immediate prefix |
| br_imm | input | 1 | Pending branch carried an immediate prefix |
| br_target | input | 32 | Pending branch target |
| flt_addr | input | 32 | Faulting address |
| flt_miss | input | 1 | 1 = TLB miss, 0 = protection fault |
| acc_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| msr_in | input | 32 | Current MSR |
| esr_in | input | 32 | Current ESR |
| done | output | 1 | Trap entry completed |
| pc_we | output | 1 | New PC valid |
| new_pc | output | 32 | Trap vector / jump target |
| lr_we | output | 1 | Link register write enable |
| lr_idx | output | 5 | Link register index |
| lr_val | output | 32 | Link register value |
| msr_we | output | 1 | MSR write enable |
| msr_nxt | output | 32 | Next MSR |
| esr_we | output | 1 | ESR write enable |
| esr_nxt | output | 32 | Next ESR |
| ear_we | output | 1 | EAR write enable |
| ear_nxt | output | 32 | Next EAR |
| btr_we | output | 1 | BTR write enable |
| btr_nxt | output | 32 | Next BTR |
| clr_flags | output | 1 | Clear delay-slot and prefix flags |
| recur_err | output | 1 | Recursive MMU fault |

## Verification
The only hidden state is the flag that remembers whether the last taken trap was an MMU fault, together with the held output registers. A corrupted flag shows up as a wrong `recur_err` on the very next MMU fault entry. The bench therefore places back-to-back MMU faults, and MMU faults separated by other classes, among its random traffic. A held data register that changes when it should not shows up on the following idle or non-writing cycle, because every output is compared against its last expected value in every cycle.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_en,
  input  logic          req_mmu,
  input  logic          req_hwexc,
  input  logic          req_hwbrk,
  input  logic          req_swbrk,
  input  logic          req_irq,
  input  logic [AW-1:0] pc,
  input  logic          in_dslot,
  input  logic          in_imm,
  input  logic          br_imm,
  input  logic [AW-1:0] br_target,
  input  logic [AW-1:0] flt_addr,
  input  logic          flt_miss,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] msr_in,
  input  logic [AW-1:0] esr_in,
  output logic          done,
  output logic          pc_we,
  output logic [AW-1:0] new_pc,
  output logic          lr_we,
  output logic [4:0]    lr_idx,
  output logic [AW-1:0] lr_val,
  output logic          msr_we,
  output logic [AW-1:0] msr_nxt,
  output logic          esr_we,
  output logic [AW-1:0] esr_nxt,
  output logic          ear_we,
  output logic [AW-1:0] ear_nxt,
  output logic          btr_we,
  output logic [AW-1:0] btr_nxt,
  output logic          clr_flags,
  output logic          recur_err
);
  localparam int IE_B = 1, BIP_B = 3, EIP_B = 9, DS_B = 12, ST_B = 10;
  localparam int UM_B = 11, UMS_B = 12, VM_B = 13, VMS_B = 14;
  localparam logic [AW-1:0] VEC_EXC = AW'(32'h20);
  localparam logic [AW-1:0] VEC_IRQ = AW'(32'h10);
  localparam logic [AW-1:0] VEC_HBK = AW'(32'h18);
  localparam logic [AW-1:0] SAVE_CLR =
    ~((AW'(1) << VM_B) | (AW'(1) << UM_B) | (AW'(1) << VMS_B) | (AW'(1) << UMS_B));

  logic hw_ok, t_mmu, t_hw, t_hb, t_sb, t_irq, t_any, t_exc;
  logic last_mmu;
  logic [AW-1:0] msr_sv, msr_c, pc_c, esr_c, lr_c, ret_mmu;
  logic [4:0] idx_c;
  logic [4:0] code;

  assign hw_ok = req_hwexc & exc_en;
  assign t_mmu = req_mmu;
  assign t_hw  = ~req_mmu & hw_ok;
  assign t_hb  = ~req_mmu & ~hw_ok & req_hwbrk;
  assign t_sb  = ~req_mmu & ~hw_ok & ~req_hwbrk & req_swbrk;
  assign t_irq = ~req_mmu & ~hw_ok & ~req_hwbrk & ~req_swbrk & req_irq;
  assign t_exc = t_mmu | t_hw;
  assign t_any = t_exc | t_hb | t_sb | t_irq;

  assign msr_sv = (msr_in & SAVE_CLR)
                | (AW'(msr_in[VM_B]) << VMS_B)
                | (AW'(msr_in[UM_B]) << UMS_B);

  assign ret_mmu = in_dslot ? (pc - (br_imm ? AW'(8) : AW'(4)))
                            : (pc - (in_imm ? AW'(4) : AW'(0)));

  assign code = {3'b100, flt_miss, acc_kind == 2'b10};

  always_comb begin
    msr_c = msr_sv;
    pc_c  = VEC_EXC;
    lr_c  = pc;
    idx_c = 5'd17;
    esr_c = (esr_in & ~(AW'(1) << DS_B)) | (AW'(in_dslot) << DS_B);
    if (t_exc) msr_c[EIP_B] = 1'b1;
    if (t_mmu) begin
      lr_c  = ret_mmu;
      esr_c = AW'(code) | (AW'(acc_kind == 2'b01) << ST_B) | (AW'(in_dslot) << DS_B);
    end else if (t_hw) begin
      lr_c  = pc + AW'(4);
    end else if (t_hb) begin
      idx_c = 5'd16;
      pc_c  = VEC_HBK;
      msr_c[BIP_B] = 1'b1;
    end else if (t_sb) begin
      pc_c  = br_target;
      msr_c[BIP_B] = 1'b1;
    end else begin
      idx_c = 5'd14;
      pc_c  = VEC_IRQ;
      msr_c[IE_B] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; pc_we <= 1'b0; lr_we <= 1'b0; msr_we <= 1'b0;
      esr_we <= 1'b0; ear_we <= 1'b0; btr_we <= 1'b0;
      clr_flags <= 1'b0; recur_err <= 1'b0; last_mmu <= 1'b0;
      new_pc <= '0; lr_idx <= '0; lr_val <= '0; msr_nxt <= '0;
      esr_nxt <= '0; ear_nxt <= '0; btr_nxt <= '0;
    end else begin
      done      <= t_any;
      pc_we     <= t_any;
      msr_we    <= t_any;
      lr_we     <= t_any & ~t_sb;
      esr_we    <= t_exc;
      ear_we    <= t_mmu;
      btr_we    <= t_exc & in_dslot;
      clr_flags <= t_exc;
      recur_err <= t_mmu & last_mmu;
      if (t_any) begin
        last_mmu <= t_mmu;
        new_pc   <= pc_c;
        msr_nxt  <= msr_c;
      end
      if (t_any & ~t_sb) begin
        lr_idx <= idx_c;
        lr_val <= lr_c;
      end
      if (t_exc) esr_nxt <= esr_c;
      if (t_mmu) ear_nxt <= flt_addr;
      if (t_exc & in_dslot) btr_nxt <= br_target;
    end
  end
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_en,
  input logic        req_mmu,
  input logic        req_hwexc,
  input logic        req_hwbrk,
  input logic        req_swbrk,
  input logic        req_irq,
  input logic [31:0] pc,
  input logic [31:0] flt_addr,
  input logic        done,
  input logic [31:0] new_pc,
  input logic [4:0]  lr_idx,
  input logic [31:0] lr_val,
  input logic [31:0] msr_nxt,
  input logic        ear_we,
  input logic [31:0] ear_nxt,
  input logic        recur_err
);
  logic any_req;
  assign any_req = req_mmu | req_hwexc | req_hwbrk | req_swbrk | req_irq;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !done && $stable(new_pc) && $stable(msr_nxt) && $stable(lr_val));

  // R6
  mmu_ear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_mmu |=> done && ear_we && ear_nxt == $past(flt_addr));

  // R4
  hwexc_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_hwexc && exc_en && !req_mmu |=> new_pc == 32'h20 && lr_idx == 5'd17
      && lr_val == $past(pc) + 32'd4);

  // R8
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_irq && !req_mmu && !req_hwexc && !req_hwbrk && !req_swbrk |=>
      new_pc == 32'h10 && lr_idx == 5'd14 && !msr_nxt[1]);

  // R7
  vm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !msr_nxt[13] && !msr_nxt[11]);

  // R12
  recur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_mmu && $past(req_mmu) |=> recur_err);
endmodule

bind trap_entry_seq trap_entry_seq_chk chk_i (.*);

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic exc_en, req_mmu, req_hwexc, req_hwbrk, req_swbrk, req_irq;
  logic [31:0] pc, br_target, flt_addr, msr_in, esr_in;
  logic in_dslot, in_imm, br_imm, flt_miss;
  logic [1:0] acc_kind;
  logic done, pc_we, lr_we, msr_we, esr_we, ear_we, btr_we, clr_flags, recur_err;
  logic [4:0] lr_idx;
  logic [31:0] new_pc, lr_val, msr_nxt, esr_nxt, ear_nxt, btr_nxt;

  int total = 0, bad = 0;
  bit finished = 0;

  // expected state
  logic e_last_mmu;
  logic [31:0] e_pc, e_lr, e_msr, e_esr, e_ear, e_btr;
  logic [4:0] e_idx;
  logic e_done, e_lrwe, e_esrwe, e_earwe, e_btrwe, e_clr, e_rec;
  string cls;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_seq dut_i (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] shadow(input logic [31:0] m);
    logic [31:0] r;
    r = m;
    r[14] = m[13];
    r[12] = m[11];
    r[13] = 1'b0;
    r[11] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] mmu_ret(input logic [31:0] p, input logic ds, input logic im, input logic bi);
    if (ds && bi) return p - 32'd8;
    if (ds) return p - 32'd4;
    if (im) return p - 32'd4;
    return p;
  endfunction

  function automatic logic [31:0] mmu_esr(input logic miss, input logic [1:0] k, input logic ds);
    logic [31:0] v;
    v = miss ? 32'd18 : 32'd16;
    if (k == 2'b10) v = v + 32'd1;
    if (k == 2'b01) v[10] = 1'b1;
    if (ds) v[12] = 1'b1;
    return v;
  endfunction

  task automatic model();
    logic [31:0] m;
    e_done = 0; e_lrwe = 0; e_esrwe = 0; e_earwe = 0; e_btrwe = 0; e_clr = 0; e_rec = 0;
    m = shadow(msr_in);
    cls = "R2";
    if (req_mmu) begin
      cls = "R5"; e_done = 1; e_lrwe = 1; e_esrwe = 1; e_earwe = 1; e_clr = 1;
      e_rec = e_last_mmu; e_last_mmu = 1;
      e_pc = 32'h20; e_idx = 17; e_lr = mmu_ret(pc, in_dslot, in_imm, br_imm);
      m[9] = 1; e_msr = m; e_esr = mmu_esr(flt_miss, acc_kind, in_dslot); e_ear = flt_addr;
      if (in_dslot) begin e_btrwe = 1; e_btr = br_target; end
    end else if (req_hwexc && exc_en) begin
      cls = "R4"; e_done = 1; e_lrwe = 1; e_esrwe = 1; e_clr = 1; e_last_mmu = 0;
      e_pc = 32'h20; e_idx = 17; e_lr = pc + 32'd4; m[9] = 1; e_msr = m;
      e_esr = esr_in; e_esr[12] = in_dslot;
      if (in_dslot) begin e_btrwe = 1; e_btr = br_target; end
    end else if (req_hwbrk) begin
      cls = "R9"; e_done = 1; e_lrwe = 1; e_last_mmu = 0;
      e_pc = 32'h18; e_idx = 16; e_lr = pc; m[3] = 1; e_msr = m;
    end else if (req_swbrk) begin
      cls = "R10"; e_done = 1; e_last_mmu = 0;
      e_pc = br_target; m[3] = 1; e_msr = m;
    end else if (req_irq) begin
      cls = "R8"; e_done = 1; e_lrwe = 1; e_last_mmu = 0;
      e_pc = 32'h10; e_idx = 14; e_lr = pc; m[1] = 0; e_msr = m;
    end
  endtask

  task automatic check_all();
    chk("R3", "done", 32'(done), 32'(e_done));
    chk("R3", "pc_we", 32'(pc_we), 32'(e_done));
    chk(cls, "new_pc", new_pc, e_pc);
    chk(cls, "lr_we", 32'(lr_we), 32'(e_lrwe));
    chk(cls, "lr_idx", 32'(lr_idx), 32'(e_idx));
    chk(cls, "lr_val", lr_val, e_lr);
    chk("R7", "msr_we", 32'(msr_we), 32'(e_done));
    chk("R7", "msr_nxt", msr_nxt, e_msr);
    chk("R6", "esr_we", 32'(esr_we), 32'(e_esrwe));
    chk(cls == "R5" ? "R6" : cls, "esr_nxt", esr_nxt, e_esr);
    chk("R6", "ear_we", 32'(ear_we), 32'(e_earwe));
    chk("R6", "ear_nxt", ear_nxt, e_ear);
    chk(cls, "btr_we", 32'(btr_we), 32'(e_btrwe));
    chk(cls, "btr_nxt", btr_nxt, e_btr);
    chk("R11", "clr_flags", 32'(clr_flags), 32'(e_clr));
    chk("R12", "recur_err", 32'(recur_err), 32'(e_rec));
  endtask

  task automatic apply(input logic [4:0] reqs, input logic en);
    {req_mmu, req_hwexc, req_hwbrk, req_swbrk, req_irq} = reqs;
    exc_en = en;
    model();
    @(negedge clk);
    check_all();
  endtask

  task automatic rand_ops();
    pc = $urandom() & 32'hFFFF_FFFC; br_target = $urandom(); flt_addr = $urandom();
    msr_in = $urandom(); esr_in = $urandom();
    {in_dslot, in_imm, br_imm, flt_miss} = 4'($urandom());
    acc_kind = 2'($urandom());
  endtask

  initial begin
    void'($urandom(32'd20240611));
    {exc_en, req_mmu, req_hwexc, req_hwbrk, req_swbrk, req_irq} = '0;
    {pc, br_target, flt_addr, msr_in, esr_in} = '0;
    {in_dslot, in_imm, br_imm, flt_miss} = '0; acc_kind = 0;
    e_last_mmu = 0; e_pc = 0; e_lr = 0; e_msr = 0; e_esr = 0; e_ear = 0; e_btr = 0; e_idx = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_all_reset();
    rst_n = 1'b1;
    @(negedge clk);
    e_done = 0; e_lrwe = 0; e_esrwe = 0; e_earwe = 0; e_btrwe = 0; e_clr = 0; e_rec = 0; cls = "R1";
    check_all();

    // R2 idle with junk inputs
    rand_ops(); apply(5'b00000, 1);
    // R4 hwexc in delay slot
    rand_ops(); in_dslot = 1; apply(5'b01000, 1);
    // R3 hwexc disabled alone: nothing changes
    rand_ops(); apply(5'b01000, 0);
    // R3 hwexc disabled with irq: irq taken
    rand_ops(); apply(5'b01001, 0);
    // R5 dslot + br_imm: pc-8
    rand_ops(); in_dslot = 1; br_imm = 1; apply(5'b10000, 1);
    // R12 back-to-back mmu; R5 imm only
    rand_ops(); in_dslot = 0; in_imm = 1; flt_miss = 1; acc_kind = 2'b10; apply(5'b10000, 1);
    // R6 store protection fault
    rand_ops(); in_dslot = 0; in_imm = 0; flt_miss = 0; acc_kind = 2'b01; apply(5'b10000, 1);
    // R9 hardware break, R10 software break
    rand_ops(); apply(5'b00100, 1);
    rand_ops(); apply(5'b00010, 1);
    // R8 interrupt, then all at once: MMU wins
    rand_ops(); apply(5'b00001, 1);
    rand_ops(); apply(5'b11111, 1);
    rand_ops(); apply(5'b01111, 1);
    rand_ops(); apply(5'b00111, 1);
    rand_ops(); apply(5'b00011, 1);

    for (int i = 0; i < 600; i++) begin
      logic [4:0] r;
      rand_ops();
      r = 5'($urandom()) & 5'($urandom());
      apply(r, ($urandom() % 4) != 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check_all_reset();
    chk("R1", "done", 32'(done), 0);
    chk("R1", "lr_we", 32'(lr_we), 0);
    chk("R1", "new_pc", new_pc, 0);
    chk("R1", "msr_nxt", msr_nxt, 0);
    chk("R1", "recur_err", 32'(recur_err), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule